// File: doc/BRIEF.md
# Per-Register Floating-Point Exception Flag File

This block keeps one hidden exception bit beside each of 64 general registers, so floating-point code can run ahead without a serializing barrier on a global status word. Every register write presents its destination index, the result data, a write mode and the five raw status bits from the arithmetic unit. The status is filtered by an enable mask taken from the FPU control register. Any NaN found in the result is ORed in, and the single resulting bit is stored with the destination register. Integer writes always store 0, so a value changed by integer instructions (sign flips, exponent tweaks) loses its flag.

Two operand read ports return the flags of an instruction's sources, and the block raises a trap request when an issuing FP instruction has a flagged valid source and trapping is enabled. A separate query port serves flag-conditional jump and move instructions. A full-width save/restore port reads out or replaces the whole flag vector on a task switch. In SIMD mode, all lanes of a vector register collapse into one flag.

Top module: `fp_xflag_file`

## Requirements
- R1: After reset is released, every flag reads 0 on `ctx_rdata_o`, the read ports and the query port.
- R2: A write with `wr_mode_i` of 1 (FP32), 2 (FP64) or 3 (SIMD 2x32) to a nonzero index stores OR-reduce(`wr_status_i` AND `xmask_i`) OR nan. The status bits are [0] invalid, [1] divide-by-zero, [2] overflow, [3] underflow, [4] inexact.
- R3: A write with `wr_mode_i` = 0 (integer) stores 0 for any status, mask and data.
- R4: A status bit whose `xmask_i` bit is 0 has no effect on the stored flag.
- R5: NaN detection is exponent all ones with a nonzero fraction. FP32 checks data[30:23] and data[22:0] only. FP64 checks data[62:52] and data[51:0]. Infinities do not set the flag.
- R6: In SIMD mode the two 32-bit lanes (data[31:0], data[63:32]) are each checked as FP32. The single flag is set if either lane is NaN or the masked status is nonzero.
- R7: Register 0 always reads flag 0 on every port. Normal and save/restore writes to it are ignored.
- R8: A read or query port addressing a register written in the same cycle returns the new flag.
- R9: When `ctx_we_i` is high, the next state of all flags is `ctx_wdata_i` (bit 0 forced to 0). This write wins over a simultaneous normal write, and `ctx_rdata_o` presents the stored flag vector.
- R10: `qry_flag_o` returns the flag of register `qry_idx_i`.
- R11: `trap_req_o` is 1 exactly when `issue_fp_i` and `trap_en_i` are 1 and some read port p with `issue_src_vld_i[p]` = 1 returns a set flag.
- R12: With neither `wr_en_i` nor `ctx_we_i` high, the stored flags do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_idx_i | input | 6 | Destination register index |
| wr_data_i | input | 64 | Result data written |
| wr_mode_i | input | 2 | 0 integer, 1 FP32, 2 FP64, 3 SIMD 2x32 |
| wr_status_i | input | 5 | Raw FPU status: invalid, div0, overflow, underflow, inexact (bit 0 up) |
| xmask_i | input | 5 | Status enable mask from FPU control register |
| rd_idx_i | input | 12 | Two packed 6-bit source indices |
| rd_flag_o | output | 2 | Flag of each source index |
| issue_fp_i | input | 1 | An FP instruction is issuing |
| issue_src_vld_i | input | 2 | Which read ports carry real FP sources |
| trap_en_i | input | 1 | Trapping on flagged operands enabled |
| trap_req_o | output | 1 | Trap request |
| qry_idx_i | input | 6 | Register tested by flag-conditional jump/move |
| qry_flag_o | output | 1 | Flag of the queried register |
| ctx_we_i | input | 1 | Restore strobe for the whole flag vector |
| ctx_wdata_i | input | 64 | Flag vector to restore |
| ctx_rdata_o | output | 64 | Stored flag vector for saving |

## Verification
A normal write, a read of the same register and a save/restore write can all fall in one cycle. The bench drives a write while a read port and the query port address the destination, and it judges the outputs before the edge against the flag computed for that write. It also drives a restore together with a normal write whose flag is the opposite of the restored bit. The bench then requires the restored value, both on the same-cycle read port and in `ctx_rdata_o` after the edge.

// File: rtl/fp_xflag_pkg.sv
package fp_xflag_pkg;
  typedef enum logic [1:0] {
    WM_INT = 2'd0,
    WM_F32 = 2'd1,
    WM_F64 = 2'd2,
    WM_V32 = 2'd3
  } wr_mode_e;

  localparam int ST_W = 5;
  localparam int F32_EXP_W = 8;
  localparam int F32_FRC_W = 23;
  localparam int F64_EXP_W = 11;
  localparam int F64_FRC_W = 52;
endpackage

// File: rtl/fp_nan_detect.sv
module fp_nan_detect
  import fp_xflag_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        mode_i,
  output logic              nan_o
);
  localparam int N32 = DATA_W / 32;
  localparam int N64 = DATA_W / 64;

  logic [N32-1:0] nan32;
  logic [N64-1:0] nan64;

  for (genvar g = 0; g < N32; g++) begin : g_l32
    assign nan32[g] = (&data_i[g*32+F32_FRC_W +: F32_EXP_W]) &&
                      (|data_i[g*32 +: F32_FRC_W]);
  end

  for (genvar g = 0; g < N64; g++) begin : g_l64
    assign nan64[g] = (&data_i[g*64+F64_FRC_W +: F64_EXP_W]) &&
                      (|data_i[g*64 +: F64_FRC_W]);
  end

  always_comb begin
    unique case (wr_mode_e'(mode_i))
      WM_F32:  nan_o = nan32[0];
      WM_F64:  nan_o = |nan64;
      WM_V32:  nan_o = |nan32;   // any lane collapses into one flag
      default: nan_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fp_xflag_eval.sv
module fp_xflag_eval
  import fp_xflag_pkg::*;
(
  input  logic [ST_W-1:0] status_i,
  input  logic [ST_W-1:0] mask_i,
  input  logic [1:0]      mode_i,
  input  logic            nan_i,
  output logic            flag_o
);
  logic is_fp;
  assign is_fp  = wr_mode_e'(mode_i) != WM_INT;
  assign flag_o = is_fp && ((|(status_i & mask_i)) || nan_i);
endmodule

// File: rtl/fp_xflag_regs.sv
module fp_xflag_regs #(
  parameter int NUM_REGS = 64,
  parameter int NUM_RD   = 2,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [IDX_W-1:0]        wr_idx_i,
  input  logic                    wr_flag_i,
  input  logic                    ctx_we_i,
  input  logic [NUM_REGS-1:0]     ctx_wdata_i,
  input  logic [NUM_RD*IDX_W-1:0] rd_idx_i,
  output logic [NUM_RD-1:0]       rd_flag_o,
  input  logic [IDX_W-1:0]        qry_idx_i,
  output logic                    qry_flag_o,
  output logic [NUM_REGS-1:0]     flags_o
);
  logic [NUM_REGS-1:0] flags_q, flags_nxt;

  // restore beats normal write; register 0 pinned to 0
  always_comb begin
    flags_nxt = flags_q;
    if (ctx_we_i)     flags_nxt = ctx_wdata_i;
    else if (wr_en_i) flags_nxt[wr_idx_i] = wr_flag_i;
    flags_nxt[0] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_nxt;
  end

  // reads see next state: write-before-read bypass
  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    assign rd_flag_o[p] = flags_nxt[rd_idx_i[p*IDX_W +: IDX_W]];
  end
  assign qry_flag_o = flags_nxt[qry_idx_i];
  assign flags_o    = flags_q;
endmodule

// File: rtl/fp_xflag_file.sv
module fp_xflag_file
  import fp_xflag_pkg::*;
#(
  parameter int NUM_REGS = 64,
  parameter int DATA_W   = 64,
  parameter int NUM_RD   = 2,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [IDX_W-1:0]        wr_idx_i,
  input  logic [DATA_W-1:0]       wr_data_i,
  input  logic [1:0]              wr_mode_i,
  input  logic [ST_W-1:0]         wr_status_i,
  input  logic [ST_W-1:0]         xmask_i,
  input  logic [NUM_RD*IDX_W-1:0] rd_idx_i,
  output logic [NUM_RD-1:0]       rd_flag_o,
  input  logic                    issue_fp_i,
  input  logic [NUM_RD-1:0]       issue_src_vld_i,
  input  logic                    trap_en_i,
  output logic                    trap_req_o,
  input  logic [IDX_W-1:0]        qry_idx_i,
  output logic                    qry_flag_o,
  input  logic                    ctx_we_i,
  input  logic [NUM_REGS-1:0]     ctx_wdata_i,
  output logic [NUM_REGS-1:0]     ctx_rdata_o
);
  logic nan;
  logic wr_flag;

  fp_nan_detect #(.DATA_W(DATA_W)) u_nan (
    .data_i (wr_data_i),
    .mode_i (wr_mode_i),
    .nan_o  (nan)
  );

  fp_xflag_eval u_eval (
    .status_i (wr_status_i),
    .mask_i   (xmask_i),
    .mode_i   (wr_mode_i),
    .nan_i    (nan),
    .flag_o   (wr_flag)
  );

  fp_xflag_regs #(.NUM_REGS(NUM_REGS), .NUM_RD(NUM_RD)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_idx_i    (wr_idx_i),
    .wr_flag_i   (wr_flag),
    .ctx_we_i    (ctx_we_i),
    .ctx_wdata_i (ctx_wdata_i),
    .rd_idx_i    (rd_idx_i),
    .rd_flag_o   (rd_flag_o),
    .qry_idx_i   (qry_idx_i),
    .qry_flag_o  (qry_flag_o),
    .flags_o     (ctx_rdata_o)
  );

  assign trap_req_o = issue_fp_i && trap_en_i && (|(issue_src_vld_i & rd_flag_o));
endmodule

// File: rtl/fp_xflag_chk.sv
module fp_xflag_chk #(
  parameter int NUM_REGS = 64,
  parameter int NUM_RD   = 2,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    wr_en_i,
  input logic [IDX_W-1:0]        wr_idx_i,
  input logic [1:0]              wr_mode_i,
  input logic [4:0]              wr_status_i,
  input logic [4:0]              xmask_i,
  input logic [NUM_RD*IDX_W-1:0] rd_idx_i,
  input logic [NUM_RD-1:0]       rd_flag_o,
  input logic                    issue_fp_i,
  input logic                    trap_en_i,
  input logic                    trap_req_o,
  input logic                    ctx_we_i,
  input logic [NUM_REGS-1:0]     ctx_wdata_i,
  input logic [NUM_REGS-1:0]     ctx_rdata_o
);
  a_r2_fp_status_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !ctx_we_i && wr_mode_i != 2'd0 && wr_idx_i != '0 && |(wr_status_i & xmask_i)
    |=> ctx_rdata_o[$past(wr_idx_i)]);

  a_r3_int_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !ctx_we_i && wr_mode_i == 2'd0 |=> !ctx_rdata_o[$past(wr_idx_i)]);

  a_r7_zero_reg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctx_rdata_o[0]);

  a_r8_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !ctx_we_i && rd_idx_i[IDX_W-1:0] == wr_idx_i
    |=> ctx_rdata_o[$past(wr_idx_i)] == $past(rd_flag_o[0]));

  a_r9_ctx_restore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctx_we_i |=> ctx_rdata_o == ($past(ctx_wdata_i) & ~NUM_REGS'(1)));

  a_r11_trap_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_req_o |-> issue_fp_i && trap_en_i);

  a_r12_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i && !ctx_we_i |=> $stable(ctx_rdata_o));
endmodule

bind fp_xflag_file fp_xflag_chk #(.NUM_REGS(NUM_REGS), .NUM_RD(NUM_RD)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_idx_i    (wr_idx_i),
  .wr_mode_i   (wr_mode_i),
  .wr_status_i (wr_status_i),
  .xmask_i     (xmask_i),
  .rd_idx_i    (rd_idx_i),
  .rd_flag_o   (rd_flag_o),
  .issue_fp_i  (issue_fp_i),
  .trap_en_i   (trap_en_i),
  .trap_req_o  (trap_req_o),
  .ctx_we_i    (ctx_we_i),
  .ctx_wdata_i (ctx_wdata_i),
  .ctx_rdata_o (ctx_rdata_o)
);

// File: tb/fp_xflag_file_bench.sv
module fp_xflag_file_bench;
  localparam int NR = 64;
  localparam int IW = 6;
  localparam int DW = 64;
  localparam int NP = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic [IW-1:0]   wr_idx = '0;
  logic [DW-1:0]   wr_data = '0;
  logic [1:0]      wr_mode = '0;
  logic [4:0]      wr_status = '0;
  logic [4:0]      xmask = '0;
  logic [NP*IW-1:0] rd_idx = '0;
  logic [NP-1:0]   rd_flag;
  logic            issue_fp = 1'b0;
  logic [NP-1:0]   src_vld = '0;
  logic            trap_en = 1'b0;
  logic            trap_req;
  logic [IW-1:0]   qry_idx = '0;
  logic            qry_flag;
  logic            ctx_we = 1'b0;
  logic [NR-1:0]   ctx_wdata = '0;
  logic [NR-1:0]   ctx_rdata;

  always #2 clk = ~clk;

  fp_xflag_file u_fp_xflag_file (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data), .wr_mode_i(wr_mode),
    .wr_status_i(wr_status), .xmask_i(xmask),
    .rd_idx_i(rd_idx), .rd_flag_o(rd_flag),
    .issue_fp_i(issue_fp), .issue_src_vld_i(src_vld), .trap_en_i(trap_en), .trap_req_o(trap_req),
    .qry_idx_i(qry_idx), .qry_flag_o(qry_flag),
    .ctx_we_i(ctx_we), .ctx_wdata_i(ctx_wdata), .ctx_rdata_o(ctx_rdata)
  );

  int vecs = 0;
  int errs = 0;
  logic [NR-1:0] mdl = '0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] nxt(input logic [63:0] s);
    logic [63:0] t = s;
    t = t ^ (t << 13);
    t = t ^ (t >> 7);
    t = t ^ (t << 17);
    return t;
  endfunction

  function automatic bit is_nan32(input logic [31:0] w);
    return (((w >> 23) % 256) == 255) && ((w % (1 << 23)) != 0);
  endfunction

  function automatic bit is_nan64(input logic [63:0] w);
    return (((w >> 52) % 2048) == 2047) && ((w % (64'd1 << 52)) != 0);
  endfunction

  function automatic bit exp_flag(input int idx, input int m, input logic [63:0] d,
                                  input logic [4:0] st, input logic [4:0] mk);
    bit nan;
    if (idx == 0 || m == 0) return 1'b0;
    case (m)
      1:       nan = is_nan32(d[31:0]);
      2:       nan = is_nan64(d);
      default: nan = is_nan32(d[31:0]) || is_nan32(d[63:32]);
    endcase
    return ((st & mk) != 0) || nan;
  endfunction

  // one write; same-cycle read/query checked before edge, query after edge
  task automatic do_wr(input string req, input int idx, input int m, input logic [63:0] d,
                       input logic [4:0] st, input logic [4:0] mk);
    bit e;
    e = exp_flag(idx, m, d, st, mk);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_mode = 2'(m); wr_data = d;
    wr_status = st; xmask = mk;
    rd_idx = {IW'(0), IW'(idx)}; qry_idx = IW'(idx);
    #1;
    chk({req, " R8 bypass rd"}, 64'(rd_flag[0]), 64'(e));
    chk({req, " R8 bypass qry"}, 64'(qry_flag), 64'(e));
    @(negedge clk);
    wr_en = 1'b0;
    if (idx != 0) mdl[idx] = e;
    #1;
    chk({req, " R10 qry"}, 64'(qry_flag), 64'(mdl[idx]));
  endtask

  initial begin
    #(4 * 150000);
    errs++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [31:0] p32 [3];
    logic [63:0] pdat [13];
    logic [NR-1:0] pat;
    int n;
    p32[0] = 32'h3F80_0000; p32[1] = 32'h7FC0_0000; p32[2] = 32'h7F80_0000;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 ctx", ctx_rdata, '0);
    for (int i = 0; i < NR; i++) begin
      qry_idx = IW'(i); rd_idx = {IW'(i), IW'(i)};
      #1;
      chk("R1 qry", 64'(qry_flag), 0);
      chk("R1 rd", 64'(rd_flag), 0);
    end

    // R2/R4/R7: every index x every status, mask varies per index
    for (int i = 0; i < NR; i++)
      for (int s = 0; s < 32; s++)
        do_wr("R2 R4 R7 status", i, 2, 64'h3FF0_0000_0000_0000, 5'(s), 5'(i * 7) ^ 5'h0A);
    // R4: everything masked off
    for (int s = 0; s < 32; s++)
      do_wr("R4 mask off", 5 + s, 1 + (s % 3), 64'h4000_0000_3F80_0000, 5'(s), 5'h00);

    // R5/R6/R3: data patterns x modes x status cases
    n = 0;
    for (int h = 0; h < 3; h++)
      for (int l = 0; l < 3; l++) begin
        pdat[n] = {p32[h], p32[l]}; n++;
      end
    pdat[9]  = 64'h3FF0_0000_0000_0000;
    pdat[10] = 64'h7FF8_0000_0000_0000;
    pdat[11] = 64'h7FF0_0000_0000_0000;
    pdat[12] = 64'h7FF0_0000_0000_0001;
    n = 1;
    for (int k = 0; k < 13; k++)
      for (int m = 0; m < 4; m++)
        for (int c = 0; c < 3; c++) begin
          do_wr(m == 0 ? "R3 int" : (m == 3 ? "R6 simd" : "R5 nan"), n, m, pdat[k],
                c == 0 ? 5'h00 : 5'h1F, c == 2 ? 5'h1F : 5'h00);
          n = (n % 63) + 1;
        end

    // R3: set a flag, then integer write clears it
    for (int i = 1; i < NR; i += 9) begin
      do_wr("R3 set", i, 3, 64'h7FC0_0000_7FC0_0000, 5'h1F, 5'h1F);
      do_wr("R3 clear", i, 0, 64'h7FC0_0000_7FC0_0000, 5'h1F, 5'h1F);
    end

    // R12: idle cycles keep state
    repeat (5) @(negedge clk);
    #1;
    chk("R12 hold", ctx_rdata, mdl);

    // R9/R7: restore with colliding opposite normal write
    for (int t = 0; t < 16; t++) begin
      int k;
      rng = nxt(rng);
      pat = rng;
      k = int'(rng[63:58]);
      @(negedge clk);
      ctx_we = 1'b1; ctx_wdata = pat;
      wr_en = 1'b1; wr_idx = IW'(k); wr_mode = 2'd2; xmask = 5'h1F;
      wr_status = pat[k] ? 5'h00 : 5'h1F; wr_data = '0;
      rd_idx = {IW'(0), IW'(k)};
      #1;
      chk("R9 restore bypass", 64'(rd_flag[0]), 64'(k == 0 ? 1'b0 : pat[k]));
      chk("R7 port1 zero", 64'(rd_flag[1]), 0);
      @(negedge clk);
      ctx_we = 1'b0; wr_en = 1'b0;
      mdl = pat & ~NR'(1);
      #1;
      chk("R9 ctx read", ctx_rdata, mdl);
    end

    // R11: trap over random pairs x valid x issue x enable
    for (int t = 0; t < 64; t++) begin
      int a, b;
      rng = nxt(rng);
      a = int'(rng[5:0]); b = int'(rng[11:6]);
      for (int v = 0; v < 16; v++) begin
        bit e;
        rd_idx = {IW'(b), IW'(a)};
        src_vld = 2'(v); issue_fp = v[2]; trap_en = v[3];
        #1;
        e = v[2] && v[3] && ((v[0] && mdl[a]) || (v[1] && mdl[b]));
        chk("R11 trap", 64'(trap_req), 64'(e));
        chk("R10 rd flags", 64'(rd_flag), 64'({mdl[b], mdl[a]}));
      end
    end
    issue_fp = 1'b0; trap_en = 1'b0; src_vld = '0;

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule